// File: doc/BRIEF.md
# SDRAM Command Timing Guard

This block sits on the path from an SDRAM controller's command generator to the memory pins. It watches every command that is issued, the bank it targets and a write-data strobe. From these it keeps a set of per-bank and shared countdown windows, and it tells the generator in every cycle which commands may legally be issued next. A scheduler reads the permit vectors and picks only among commands that are permitted. Row opening, column access, closing and burst termination are covered. A separate warning tells the scheduler that a row has stayed open close to its maximum lifetime.

Each bank runs a two-state machine. `BK_CLOSED` is the state after reset and after a row has been closed. The transition `BK_CLOSED -> BK_OPEN` is taken on an ACTIVE to that bank. The transition `BK_OPEN -> BK_CLOSED` is taken on a PRECHARGE to that bank. No other command changes a bank's state.

Every minimum interval is given in picoseconds and is turned into a cycle count with the clock-period parameter. A speed-grade parameter selects the faster or the slower set of limits. The write-recovery and burst-stop spacings are fixed cycle counts. The open-row counter saturates at the maximum active time. It pulses the warning once when the row reaches that limit minus a margin parameter.

Top module: `sdr_timing_guard`

## Requirements
- R1: Each nanosecond limit is converted to cycles as ceil(limit / CLK_PS), with a minimum of 1. SPEED_GRADE 0 uses ACT-ACT 90, ACT-PRE 42 to 100000, PRE-ACT 18, ACT-RD/WR 18, ACT-ACT other bank 12 and data-ACT 33 ns. SPEED_GRADE 1 uses 90, 45 to 100000, 22.5, 22.5, 15 and 37.5 ns.
- R2: After reset every bank is closed. All act_ok bits and bst_ok are 1, all rd_ok, wr_ok and pre_ok bits are 0, and no warning is raised.
- R3: After an ACTIVE to bank b in cycle t, act_ok[b] stays 0 until cycle t + ACT-ACT cycles.
- R4: After an ACTIVE to bank b in cycle t, rd_ok[b] and wr_ok[b] are 0 before cycle t + ACT-RD cycles and 1 from then on while the bank is open.
- R5: After an ACTIVE to bank b in cycle t, pre_ok[b] is 0 before cycle t + minimum ACT-PRE cycles and 1 at that cycle when no write data is pending.
- R6: After a PRECHARGE to bank b in cycle t, act_ok[b] stays 0 until cycle t + PRE-ACT cycles.
- R7: After an ACTIVE to any bank in cycle t, act_ok is 0 for every bank until cycle t + ACT-ACT-other-bank cycles.
- R8: With the last write data for bank b in cycle t, pre_ok[b] is 0 in cycles t and t+1 and may be 1 from t+2. The written bank is the bank of the latest WRITE.
- R9: With the last write data for bank b in cycle t, act_ok[b] stays 0 until cycle t + data-ACT cycles.
- R10: READ or WRITE commands to an open bank may follow one another in consecutive cycles. rd_ok and wr_ok stay 1 after a READ.
- R11: ras_warn[b] is a one-cycle pulse in cycle t + (max ACT-PRE cycles - WARN_MARGIN) after an ACTIVE in cycle t, if the bank is still open. It is not raised for other banks.
- R12: Command codes are 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE and 5 BURST STOP. ACTIVE moves a bank BK_CLOSED -> BK_OPEN and PRECHARGE moves it BK_OPEN -> BK_CLOSED. rd_ok, wr_ok and pre_ok can be 1 only when the bank is open. act_ok can be 1 only when it is closed.
- R13: bst_ok is 0 in any cycle with the write-data strobe high. It is 1 in the cycle after the last write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Command issued this cycle (codes in R12) |
| bank_i | input | $clog2(NUM_BANKS) | Bank targeted by cmd_i |
| wdata_vld_i | input | 1 | Write data is on the bus this cycle |
| act_ok_o | output | NUM_BANKS | ACTIVE permitted per bank |
| rd_ok_o | output | NUM_BANKS | READ permitted per bank |
| wr_ok_o | output | NUM_BANKS | WRITE permitted per bank |
| pre_ok_o | output | NUM_BANKS | PRECHARGE permitted per bank |
| bst_ok_o | output | 1 | BURST STOP permitted |
| ras_warn_o | output | NUM_BANKS | Row-open-too-long warning pulse per bank |

## Verification
A command that is presented in cycle t is registered at the edge that closes t. The permits it affects can therefore first change in cycle t+1. A limit of N cycles releases the permit in exactly cycle t+N. The write-data strobe also acts combinationally, so it lowers pre_ok and bst_ok within its own cycle. The scoreboard stores each expectation with the absolute cycle it is due, and it checks every window at both edges: the last blocked cycle (t+N-1) and the first permitted cycle (t+N). Outputs are sampled at the falling clock edge, after inputs have settled.

// File: rtl/sdr_guard_pkg.sv
package sdr_guard_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_BST = 3'd5
    } sdr_cmd_e;

    typedef enum logic {
        BK_CLOSED = 1'b0,
        BK_OPEN   = 1'b1
    } bank_state_e;

    // ceil(limit / period), never below one cycle
    function automatic int cyc_of(input int lim_ps, input int clk_ps);
        int c;
        c = (lim_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sdr_win_cnt.sv
module sdr_win_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         done_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sdr_bank_fsm.sv
module sdr_bank_fsm
    import sdr_guard_pkg::*;
#(
    parameter int W       = 16,
    parameter int RC      = 9,
    parameter int RCD     = 2,
    parameter int RAS     = 5,
    parameter int RP      = 2,
    parameter int DPL     = 2,
    parameter int DAL     = 4,
    parameter int RASMAX  = 10000,
    parameter int WARN_AT = 9984
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic pre_i,
    input  logic wdv_i,
    output logic act_ok_o,
    output logic rdwr_ok_o,
    output logic pre_ok_o,
    output logic warn_o
);
    bank_state_e state_q, state_d;
    logic rc_done, rcd_done, ras_done, rp_done, dpl_done, dal_done;
    logic [W-1:0] open_q;

    sdr_win_cnt #(.W(W)) u_rc  (.clk(clk), .rst_n(rst_n), .load_i(act_i), .val_i(W'(RC - 1)),  .done_o(rc_done));
    sdr_win_cnt #(.W(W)) u_rcd (.clk(clk), .rst_n(rst_n), .load_i(act_i), .val_i(W'(RCD - 1)), .done_o(rcd_done));
    sdr_win_cnt #(.W(W)) u_ras (.clk(clk), .rst_n(rst_n), .load_i(act_i), .val_i(W'(RAS - 1)), .done_o(ras_done));
    sdr_win_cnt #(.W(W)) u_rp  (.clk(clk), .rst_n(rst_n), .load_i(pre_i), .val_i(W'(RP - 1)),  .done_o(rp_done));
    sdr_win_cnt #(.W(W)) u_dpl (.clk(clk), .rst_n(rst_n), .load_i(wdv_i), .val_i(W'(DPL - 1)), .done_o(dpl_done));
    sdr_win_cnt #(.W(W)) u_dal (.clk(clk), .rst_n(rst_n), .load_i(wdv_i), .val_i(W'(DAL - 1)), .done_o(dal_done));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= BK_CLOSED;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BK_CLOSED: if (act_i) state_d = BK_OPEN;
            BK_OPEN:   if (pre_i) state_d = BK_CLOSED;
        endcase
    end

    // open-row age, saturating at the maximum active time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            open_q <= '0;
        else if (act_i)
            open_q <= W'(1);
        else if (state_q == BK_OPEN && open_q != W'(RASMAX))
            open_q <= open_q + 1'b1;
    end

    // outputs
    always_comb begin
        act_ok_o  = 1'b0;
        rdwr_ok_o = 1'b0;
        pre_ok_o  = 1'b0;
        warn_o    = 1'b0;
        unique case (state_q)
            BK_CLOSED: act_ok_o = rc_done && rp_done && dal_done;
            BK_OPEN: begin
                rdwr_ok_o = rcd_done;
                pre_ok_o  = ras_done && dpl_done && !wdv_i;
                warn_o    = (open_q == W'(WARN_AT));
            end
        endcase
    end

    assert_closed_no_col_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pre_i |=> (!rdwr_ok_o && !pre_ok_o));

    generate
        if (RC > 1) begin : g_rc_chk
            assert_act_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
                act_i |=> !act_ok_o);
        end
        if (DPL > 1) begin : g_dpl_chk
            assert_wdata_to_pre_R8: assert property (@(posedge clk) disable iff (!rst_n)
                wdv_i |=> !pre_ok_o);
        end
        if (WARN_AT < RASMAX) begin : g_warn_chk
            assert_warn_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
                warn_o |=> !warn_o);
        end
    endgenerate
endmodule

// File: rtl/sdr_shared_win.sv
module sdr_shared_win #(
    parameter int NB  = 4,
    parameter int BW  = 2,
    parameter int W   = 16,
    parameter int RRD = 2,
    parameter int BDL = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any_act_i,
    input  logic          wr_cmd_i,
    input  logic [BW-1:0] bank_i,
    input  logic          wdv_i,
    output logic          rrd_done_o,
    output logic          bst_ok_o,
    output logic [BW-1:0] wbank_o
);
    logic          bdl_done;
    logic [BW-1:0] wbank_q;

    sdr_win_cnt #(.W(W)) u_rrd (.clk(clk), .rst_n(rst_n), .load_i(any_act_i), .val_i(W'(RRD - 1)), .done_o(rrd_done_o));
    sdr_win_cnt #(.W(W)) u_bdl (.clk(clk), .rst_n(rst_n), .load_i(wdv_i),     .val_i(W'(BDL - 1)), .done_o(bdl_done));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wbank_q <= '0;
        else if (wr_cmd_i)
            wbank_q <= bank_i;
    end

    // write data travels with the WRITE command in its first cycle
    assign wbank_o  = wr_cmd_i ? bank_i : wbank_q;
    assign bst_ok_o = bdl_done && !wdv_i;

    generate
        if (BDL == 1) begin : g_bdl_chk
            assert_bst_after_data_R13: assert property (@(posedge clk) disable iff (!rst_n)
                wdv_i |=> (bst_ok_o || wdv_i));
        end
    endgenerate
endmodule

// File: rtl/sdr_timing_guard.sv
module sdr_timing_guard
    import sdr_guard_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int CLK_PS      = 10000,
    parameter int SPEED_GRADE = 0,
    parameter int WARN_MARGIN = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [2:0]                   cmd_i,
    input  logic [$clog2(NUM_BANKS)-1:0] bank_i,
    input  logic                         wdata_vld_i,
    output logic [NUM_BANKS-1:0]         act_ok_o,
    output logic [NUM_BANKS-1:0]         rd_ok_o,
    output logic [NUM_BANKS-1:0]         wr_ok_o,
    output logic [NUM_BANKS-1:0]         pre_ok_o,
    output logic                         bst_ok_o,
    output logic [NUM_BANKS-1:0]         ras_warn_o
);
    localparam int BW        = $clog2(NUM_BANKS);
    localparam int RC_PS     = 90000;
    localparam int RAS_PS    = (SPEED_GRADE == 0) ? 42000 : 45000;
    localparam int RASMAX_PS = 100000000;
    localparam int RP_PS     = (SPEED_GRADE == 0) ? 18000 : 22500;
    localparam int RCD_PS    = (SPEED_GRADE == 0) ? 18000 : 22500;
    localparam int RRD_PS    = (SPEED_GRADE == 0) ? 12000 : 15000;
    localparam int DAL_PS    = (SPEED_GRADE == 0) ? 33000 : 37500;

    localparam int RC_CYC     = cyc_of(RC_PS, CLK_PS);
    localparam int RAS_CYC    = cyc_of(RAS_PS, CLK_PS);
    localparam int RASMAX_CYC = cyc_of(RASMAX_PS, CLK_PS);
    localparam int RP_CYC     = cyc_of(RP_PS, CLK_PS);
    localparam int RCD_CYC    = cyc_of(RCD_PS, CLK_PS);
    localparam int RRD_CYC    = cyc_of(RRD_PS, CLK_PS);
    localparam int DAL_CYC    = cyc_of(DAL_PS, CLK_PS);
    localparam int DPL_CYC    = 2;
    localparam int BDL_CYC    = 1;
    localparam int WARN_AT    = RASMAX_CYC - WARN_MARGIN;
    localparam int CW         = $clog2(RASMAX_CYC + 1) + 1;

    logic          is_act, is_pre, is_wr;
    logic          rrd_done;
    logic [BW-1:0] wbank;
    logic [NUM_BANKS-1:0] bank_act_ok, bank_rdwr_ok;

    assign is_act = (cmd_i == CMD_ACT);
    assign is_pre = (cmd_i == CMD_PRE);
    assign is_wr  = (cmd_i == CMD_WR);

    sdr_shared_win #(
        .NB(NUM_BANKS), .BW(BW), .W(CW), .RRD(RRD_CYC), .BDL(BDL_CYC)
    ) u_shared (
        .clk(clk), .rst_n(rst_n),
        .any_act_i(is_act), .wr_cmd_i(is_wr), .bank_i(bank_i), .wdv_i(wdata_vld_i),
        .rrd_done_o(rrd_done), .bst_ok_o(bst_ok_o), .wbank_o(wbank)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic act_here, pre_here, wdv_here;
            assign act_here = is_act && (bank_i == BW'(b));
            assign pre_here = is_pre && (bank_i == BW'(b));
            assign wdv_here = wdata_vld_i && (wbank == BW'(b));

            sdr_bank_fsm #(
                .W(CW), .RC(RC_CYC), .RCD(RCD_CYC), .RAS(RAS_CYC), .RP(RP_CYC),
                .DPL(DPL_CYC), .DAL(DAL_CYC), .RASMAX(RASMAX_CYC), .WARN_AT(WARN_AT)
            ) u_bank (
                .clk(clk), .rst_n(rst_n),
                .act_i(act_here), .pre_i(pre_here), .wdv_i(wdv_here),
                .act_ok_o(bank_act_ok[b]), .rdwr_ok_o(bank_rdwr_ok[b]),
                .pre_ok_o(pre_ok_o[b]), .warn_o(ras_warn_o[b])
            );

            assign act_ok_o[b] = bank_act_ok[b] && rrd_done;
            assign rd_ok_o[b]  = bank_rdwr_ok[b];
            assign wr_ok_o[b]  = bank_rdwr_ok[b];
        end

        if (RRD_CYC > 1) begin : g_rrd_chk
            assert_cross_bank_act_R7: assert property (@(posedge clk) disable iff (!rst_n)
                is_act |=> (act_ok_o == '0));
        end
    endgenerate

    assert_warn_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |=> $onehot0(ras_warn_o));
endmodule

// File: tb/test_sdr_timing_guard.sv
module test_sdr_timing_guard;
    localparam int CLK_PERIOD = 10;
    localparam int NB    = 4;
    localparam int T_PS  = 5000;
    localparam int MARG  = 8;

    // limits recomputed here from the requirements (grade 0, 5 ns clock)
    function automatic int up(input int ps);
        int c;
        c = (ps + T_PS - 1) / T_PS;
        return (c < 1) ? 1 : c;
    endfunction
    localparam int N_RC   = up(90000);
    localparam int N_RAS  = up(42000);
    localparam int N_RP   = up(18000);
    localparam int N_RCD  = up(18000);
    localparam int N_RRD  = up(12000);
    localparam int N_DAL  = up(33000);
    localparam int N_MAX  = up(100000000);
    localparam int N_WARN = N_MAX - MARG;

    localparam int S_ACT = 0, S_RD = 1, S_WR = 2, S_PRE = 3, S_BST = 4, S_WARN = 5;
    localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3, C_PRE = 3'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] cmd_i = C_NOP;
    logic [1:0] bank_i = '0;
    logic wdv = 1'b0;
    logic [NB-1:0] act_ok, rd_ok, wr_ok, pre_ok, warn;
    logic bst_ok;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        int    sig;
        int    bk;
        bit    val;
        string req;
    } exp_t;
    exp_t sb[$];

    sdr_timing_guard #(
        .NUM_BANKS(NB), .CLK_PS(T_PS), .SPEED_GRADE(0), .WARN_MARGIN(MARG)
    ) i_sdr_timing_guard (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i), .wdata_vld_i(wdv),
        .act_ok_o(act_ok), .rd_ok_o(rd_ok), .wr_ok_o(wr_ok), .pre_ok_o(pre_ok),
        .bst_ok_o(bst_ok), .ras_warn_o(warn)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit pick(input int sig, input int bk);
        case (sig)
            S_ACT:   return act_ok[bk];
            S_RD:    return rd_ok[bk];
            S_WR:    return wr_ok[bk];
            S_PRE:   return pre_ok[bk];
            S_BST:   return bst_ok;
            default: return warn[bk];
        endcase
    endfunction

    // monitor: pop due expectations and compare
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                bit a;
                a = pick(sb[i].sig, sb[i].bk);
                checks++;
                if (a !== sb[i].val) begin
                    fails++;
                    $display("FAIL %s: sig %0d bank %0d cycle %0d actual %0b expected %0b",
                             sb[i].req, sb[i].sig, sb[i].bk, cyc, a, sb[i].val);
                end
                sb.delete(i);
            end else if (sb[i].at < cyc) begin
                checks++;
                fails++;
                $display("FAIL %s: expectation for cycle %0d missed, actual none expected %0b",
                         sb[i].req, sb[i].at, sb[i].val);
                sb.delete(i);
            end
        end
    end

    task automatic expect_at(input int off, input int sig, input int bk, input bit v, input string req);
        exp_t e;
        e.at = cyc + off; e.sig = sig; e.bk = bk; e.val = v; e.req = req;
        sb.push_back(e);
    endtask

    task automatic put(input logic [2:0] c, input int bk, input logic dv);
        cmd_i  = c;
        bank_i = 2'(bk);
        wdv    = dv;
        @(posedge clk);
        #1;
        cmd_i = C_NOP;
        wdv   = 1'b0;
    endtask

    task automatic nops(input int n);
        for (int k = 0; k < n; k++) put(C_NOP, 0, 1'b0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2: reset state
        for (int b = 0; b < NB; b++) begin
            expect_at(0, S_ACT, b, 1'b1, "R2");
            expect_at(0, S_RD, b, 1'b0, "R2");
            expect_at(0, S_WR, b, 1'b0, "R2");
            expect_at(0, S_PRE, b, 1'b0, "R2");
            expect_at(0, S_WARN, b, 1'b0, "R2");
        end
        expect_at(0, S_BST, 0, 1'b1, "R2");
        nops(2);

        // bank 0: open, read twice, close
        expect_at(1, S_ACT, 0, 1'b0, "R3 R12");
        expect_at(N_RRD - 1, S_ACT, 1, 1'b0, "R7");
        expect_at(N_RRD, S_ACT, 1, 1'b1, "R7 R1");
        expect_at(N_RCD - 1, S_RD, 0, 1'b0, "R4");
        expect_at(N_RCD, S_RD, 0, 1'b1, "R4 R1");
        expect_at(N_RCD, S_WR, 0, 1'b1, "R4");
        expect_at(N_RCD + 1, S_RD, 0, 1'b1, "R10");
        expect_at(N_RCD + 2, S_WR, 0, 1'b1, "R10");
        expect_at(N_RAS - 1, S_PRE, 0, 1'b0, "R5");
        expect_at(N_RAS, S_PRE, 0, 1'b1, "R5 R1");
        expect_at(N_RC - 1, S_ACT, 0, 1'b0, "R3");
        expect_at(N_RC, S_ACT, 0, 1'b1, "R3 R1");
        expect_at(N_RAS + 1, S_RD, 0, 1'b0, "R12");
        expect_at(N_RAS + 1, S_PRE, 0, 1'b0, "R12");
        put(C_ACT, 0, 1'b0);
        nops(N_RCD - 1);
        put(C_RD, 0, 1'b0);
        put(C_RD, 0, 1'b0);
        nops(N_RAS - N_RCD - 2);
        put(C_PRE, 0, 1'b0);
        nops(N_RC + 2);

        // bank 1: close after the cycle limit so the precharge window governs
        put(C_ACT, 1, 1'b0);
        nops(N_RC - 1);
        expect_at(1, S_PRE, 1, 1'b0, "R12");
        expect_at(N_RP - 1, S_ACT, 1, 1'b0, "R6");
        expect_at(N_RP, S_ACT, 1, 1'b1, "R6 R1");
        put(C_PRE, 1, 1'b0);
        nops(N_RP + 2);

        // bank 2: three write beats, close, data-to-active window
        put(C_ACT, 2, 1'b0);
        nops(N_RC - 1);
        expect_at(0, S_BST, 0, 1'b0, "R13");
        expect_at(2, S_PRE, 2, 1'b0, "R8");
        expect_at(3, S_PRE, 2, 1'b0, "R8");
        expect_at(3, S_BST, 0, 1'b1, "R13");
        expect_at(4, S_PRE, 2, 1'b1, "R8");
        expect_at(2 + N_DAL - 1, S_ACT, 2, 1'b0, "R9");
        expect_at(2 + N_DAL, S_ACT, 2, 1'b1, "R9 R1");
        put(C_WR, 2, 1'b1);
        put(C_NOP, 0, 1'b1);
        put(C_NOP, 0, 1'b1);
        nops(1);
        put(C_PRE, 2, 1'b0);
        nops(N_DAL + 2);

        // bank 3: leave open until the warning fires
        expect_at(N_WARN - 1, S_WARN, 3, 1'b0, "R11");
        expect_at(N_WARN, S_WARN, 3, 1'b1, "R11 R1");
        expect_at(N_WARN + 1, S_WARN, 3, 1'b0, "R11");
        expect_at(N_WARN, S_WARN, 0, 1'b0, "R11");
        put(C_ACT, 3, 1'b0);
        nops(N_WARN + 2);
        put(C_PRE, 3, 1'b0);
        nops(4);

        if (sb.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule